// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates burst addresses for one port of a dual-port memory. It holds three registers. The counter is the live address. The field mask chooses which bits of the counter advance. The mirror keeps the most recently loaded start address, so that a burst can be replayed or can restart on its own when its field runs out.

Because the mask can hold masked bits below and above a contiguous run of counting bits, a burst can walk a middle bit-field in steps of 1, 2 or 4. The bits outside that field keep their values. A separate output flags mask values that break this contiguity rule.

Either the counter or the mask can be read back on a result bus after one of two selectable pipeline latencies. While the read-back value is shown, the data-bus output enable is dropped. An asynchronous hard clear returns everything to its power-up state. All other strobes are sampled on the rising clock edge, and when several of them arrive in the same cycle a fixed priority decides the result.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `hard_clr` is high, asynchronously and without a clock edge, the counter and mirror become 0, the mask becomes all ones, `rb_valid` becomes 0, `dq_oe` becomes 1 and `mask_bad` becomes 0.
- R2: A `ld` strobe writes `addr_in` into both the counter and the mirror at the same edge.
- R3: A `mask_ld` strobe writes `addr_in` into the mask. A mask bit of 1 marks a counting bit and a 0 marks a frozen bit.
- R4: An `inc` strobe adds the value of the lowest set mask bit to the counter, carrying only through the counting bits. Frozen bits keep their values.
- R5: If `inc` arrives while every counting bit of the counter is 1, the counter is reloaded from the mirror. Increments never change the mirror.
- R6: A `rexmit` strobe copies the mirror into the counter and leaves the mirror unchanged.
- R7: A `ctr_clr` strobe clears the counting bits of both the counter and the mirror, using the mask held before that edge. Frozen bits keep their values.
- R8: A `mask_set` strobe sets every mask bit to 1. A `mask_set` followed by a `ctr_clr` leaves the counter and the mirror at 0.
- R9: `mask_bad` is 1 after the edge that stores a mask unless the mask is nonzero, its two LSBs are not 01, and the mask with its two LSBs forced to 1 has the form 2^n−1. Examples: 1FFFFE, 07FFFF and 003FFC are legal; 02FFFF, 003FFA, 07FFE4 and 0 are illegal.
- R10: A `rb_ctr` or `rb_mask` strobe captures the counter or the mask as it stands before that edge. If both are set, the counter is captured. The value appears on `rb_data` with `rb_valid` = 1 for one cycle. With `lat_sel` = 0 this happens right after the sampling edge. With `lat_sel` = 1 it happens one edge later.
- R11: `dq_oe` is 0 exactly in the cycles where `rb_valid` is 1, and 1 otherwise.
- R12: The strobes are ordered in four tiers, highest first: {`ctr_clr`, `mask_set`}, then {`ld`, `mask_ld`}, then `rexmit`, then `inc`. Strobes within the highest active tier all take effect. Strobes in lower tiers are ignored. Readback strobes are independent of this order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| hard_clr | input | 1 | Asynchronous active-high hard clear |
| addr_in | input | W | Address or mask value for load strobes |
| ld | input | 1 | Load counter and mirror |
| mask_ld | input | 1 | Load mask |
| ctr_clr | input | 1 | Clear counting bits of counter and mirror |
| mask_set | input | 1 | Set mask to all ones |
| inc | input | 1 | Advance the counter |
| rexmit | input | 1 | Reload counter from mirror |
| rb_ctr | input | 1 | Request counter readback |
| rb_mask | input | 1 | Request mask readback |
| lat_sel | input | 1 | Readback latency select (0 short, 1 long) |
| addr_out | output | W | Current counter value |
| rb_data | output | W | Read-back value |
| rb_valid | output | 1 | Read-back value present |
| dq_oe | output | 1 | Data-bus output enable, low during readback |
| mask_bad | output | 1 | Stored mask is illegal |

## Verification
Readback and counter updates can happen in the same cycle. The bench raises `rb_ctr` together with `inc`, and requires `rb_data` to show the value from before the edge while `addr_out` has already moved on. That is done at both latencies, and with `rb_ctr` and `rb_mask` raised together. Strobes from different priority tiers are also raised together, for example load with increment, retransmit with increment, and clear with load. In each case the bench judges which one won from the next `addr_out` and from a later retransmit, which exposes the mirror.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD   = 3'd0,
    OP_CLEAR  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_REXMIT = 3'd3,
    OP_INC    = 3'd4
  } ctr_op_e;
endpackage

// File: rtl/bac_op_decode.sv
module bac_op_decode
  import burst_ctr_pkg::*;
(
  input  logic    ctr_clr,
  input  logic    mask_set,
  input  logic    ld,
  input  logic    mask_ld,
  input  logic    rexmit,
  input  logic    inc,
  output ctr_op_e op
);
  always_comb begin
    if (ctr_clr || mask_set)  op = OP_CLEAR;
    else if (ld || mask_ld)   op = OP_LOAD;
    else if (rexmit)          op = OP_REXMIT;
    else if (inc)             op = OP_INC;
    else                      op = OP_HOLD;
  end
endmodule

// File: rtl/bac_step.sv
module bac_step #(
  parameter int W = 21
) (
  input  logic [W-1:0] ctr,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] mirror,
  output logic [W-1:0] nxt
);
  logic [W-1:0] low_bit;
  logic [W-1:0] summed;
  logic         field_full;

  always_comb begin
    low_bit    = mask & (~mask + {{(W-1){1'b0}}, 1'b1});
    summed     = ctr + low_bit;
    field_full = ((ctr & mask) == mask);
    if (field_full) nxt = mirror;
    else            nxt = (ctr & ~mask) | (summed & mask);
  end
endmodule

// File: rtl/bac_mask_rule.sv
module bac_mask_rule #(
  parameter int W = 21
) (
  input  logic [W-1:0] mask,
  output logic         bad
);
  logic [W-1:0] filled;
  logic         low_ok;
  logic         run_ok;

  always_comb begin
    filled = mask | {{(W-2){1'b0}}, 2'b11};
    low_ok = (mask[1:0] != 2'b01);
    run_ok = ((filled & (filled + {{(W-1){1'b0}}, 1'b1})) == '0);
    bad    = !(low_ok && run_ok && (mask != '0));
  end
endmodule

// File: rtl/bac_readback.sv
module bac_readback #(
  parameter int W     = 21,
  parameter int LAT_A = 1,
  parameter int LAT_B = 2
) (
  input  logic         clk,
  input  logic         hard_clr,
  input  logic         req,
  input  logic [W-1:0] value,
  input  logic         lat_sel,
  output logic [W-1:0] rb_data,
  output logic         rb_valid
);
  logic [W-1:0] st_d [LAT_B];
  logic         st_v [LAT_B];

  always_ff @(posedge clk or posedge hard_clr) begin
    if (hard_clr) begin
      st_d[0] <= '0;
      st_v[0] <= 1'b0;
    end else begin
      st_d[0] <= value;
      st_v[0] <= req;
    end
  end

  for (genvar g = 1; g < LAT_B; g++) begin : g_stage
    always_ff @(posedge clk or posedge hard_clr) begin
      if (hard_clr) begin
        st_d[g] <= '0;
        st_v[g] <= 1'b0;
      end else begin
        st_d[g] <= st_d[g-1];
        st_v[g] <= st_v[g-1];
      end
    end
  end

  assign rb_data  = lat_sel ? st_d[LAT_B-1] : st_d[LAT_A-1];
  assign rb_valid = lat_sel ? st_v[LAT_B-1] : st_v[LAT_A-1];
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import burst_ctr_pkg::*;
#(
  parameter int W     = 21,
  parameter int LAT_A = 1,
  parameter int LAT_B = 2
) (
  input  logic         clk,
  input  logic         hard_clr,
  input  logic [W-1:0] addr_in,
  input  logic         ld,
  input  logic         mask_ld,
  input  logic         ctr_clr,
  input  logic         mask_set,
  input  logic         inc,
  input  logic         rexmit,
  input  logic         rb_ctr,
  input  logic         rb_mask,
  input  logic         lat_sel,
  output logic [W-1:0] addr_out,
  output logic [W-1:0] rb_data,
  output logic         rb_valid,
  output logic         dq_oe,
  output logic         mask_bad
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] ctr_q, mirror_q, mask_q;
  logic         bad_q;
  logic [W-1:0] step_nxt;
  logic         in_bad;
  logic [W-1:0] rb_sel;
  ctr_op_e      op;

  bac_op_decode u_dec (
    .ctr_clr(ctr_clr), .mask_set(mask_set), .ld(ld), .mask_ld(mask_ld),
    .rexmit(rexmit), .inc(inc), .op(op)
  );

  bac_step #(.W(W)) u_step (
    .ctr(ctr_q), .mask(mask_q), .mirror(mirror_q), .nxt(step_nxt)
  );

  bac_mask_rule #(.W(W)) u_rule (.mask(addr_in), .bad(in_bad));

  always_ff @(posedge clk or posedge hard_clr) begin
    if (hard_clr) begin
      ctr_q    <= '0;
      mirror_q <= '0;
      mask_q   <= ALL_ONES;
      bad_q    <= 1'b0;
    end else begin
      unique case (op)
        OP_CLEAR: begin
          if (ctr_clr) begin
            ctr_q    <= ctr_q & ~mask_q;
            mirror_q <= mirror_q & ~mask_q;
          end
          if (mask_set) begin
            mask_q <= ALL_ONES;
            bad_q  <= 1'b0;
          end
        end
        OP_LOAD: begin
          if (ld) begin
            ctr_q    <= addr_in;
            mirror_q <= addr_in;
          end
          if (mask_ld) begin
            mask_q <= addr_in;
            bad_q  <= in_bad;
          end
        end
        OP_REXMIT: ctr_q <= mirror_q;
        OP_INC:    ctr_q <= step_nxt;
        default:   ctr_q <= ctr_q;
      endcase
    end
  end

  assign rb_sel = rb_ctr ? ctr_q : mask_q;

  bac_readback #(.W(W), .LAT_A(LAT_A), .LAT_B(LAT_B)) u_rb (
    .clk(clk), .hard_clr(hard_clr), .req(rb_ctr | rb_mask), .value(rb_sel),
    .lat_sel(lat_sel), .rb_data(rb_data), .rb_valid(rb_valid)
  );

  assign addr_out = ctr_q;
  assign dq_oe    = ~rb_valid;
  assign mask_bad = bad_q;
endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
  parameter int W = 21
) (
  input logic         clk,
  input logic         hard_clr,
  input logic [W-1:0] addr_in,
  input logic         ld,
  input logic         mask_ld,
  input logic         ctr_clr,
  input logic         mask_set,
  input logic         inc,
  input logic         rexmit,
  input logic         rb_ctr,
  input logic         rb_mask,
  input logic         lat_sel,
  input logic [W-1:0] addr_out,
  input logic         rb_valid,
  input logic [W-1:0] mirror,
  input logic [W-1:0] mask
);
  logic upper_idle;
  assign upper_idle = !ld && !mask_ld && !ctr_clr && !mask_set;

  assert_load_R2: assert property (@(posedge clk) disable iff (hard_clr)
    (ld && !ctr_clr && !mask_set) |=> (addr_out == $past(addr_in)));

  assert_inc_frozen_R4: assert property (@(posedge clk) disable iff (hard_clr)
    (inc && upper_idle && !rexmit && ((addr_out & mask) != mask))
      |=> ((addr_out & ~mask) == $past(addr_out & ~mask)));

  assert_mirror_hold_R5: assert property (@(posedge clk) disable iff (hard_clr)
    (!ld && !ctr_clr) |=> $stable(mirror));

  assert_rexmit_R6: assert property (@(posedge clk) disable iff (hard_clr)
    (rexmit && upper_idle) |=> (addr_out == $past(mirror)));

  assert_clr_R7: assert property (@(posedge clk) disable iff (hard_clr)
    ctr_clr |=> ((addr_out & $past(mask)) == '0));

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (hard_clr)
    mask_set |=> (mask == {W{1'b1}}));

  assert_rb_fast_R10: assert property (@(posedge clk) disable iff (hard_clr)
    ((rb_ctr || rb_mask) && !lat_sel) |=> (rb_valid || lat_sel));
endmodule

bind burst_addr_ctr bac_checker #(.W(W)) u_chk (
  .clk(clk), .hard_clr(hard_clr), .addr_in(addr_in), .ld(ld),
  .mask_ld(mask_ld), .ctr_clr(ctr_clr), .mask_set(mask_set), .inc(inc),
  .rexmit(rexmit), .rb_ctr(rb_ctr), .rb_mask(rb_mask), .lat_sel(lat_sel),
  .addr_out(addr_out), .rb_valid(rb_valid), .mirror(mirror_q), .mask(mask_q)
);

// File: tb/test_burst_addr_ctr.sv
module test_burst_addr_ctr;
  localparam int W = 21;
  localparam logic [W-1:0] ALL = {W{1'b1}};

  logic         clk = 1'b0;
  logic         hard_clr = 1'b1;
  logic [W-1:0] addr_in = '0;
  logic ld = 0, mask_ld = 0, ctr_clr = 0, mask_set = 0, inc = 0, rexmit = 0;
  logic rb_ctr = 0, rb_mask = 0, lat_sel = 0;
  logic [W-1:0] addr_out, rb_data;
  logic         rb_valid, dq_oe, mask_bad;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  burst_addr_ctr #(.W(W)) i_burst_addr_ctr (
    .clk(clk), .hard_clr(hard_clr), .addr_in(addr_in), .ld(ld),
    .mask_ld(mask_ld), .ctr_clr(ctr_clr), .mask_set(mask_set), .inc(inc),
    .rexmit(rexmit), .rb_ctr(rb_ctr), .rb_mask(rb_mask), .lat_sel(lat_sel),
    .addr_out(addr_out), .rb_data(rb_data), .rb_valid(rb_valid),
    .dq_oe(dq_oe), .mask_bad(mask_bad)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    ld = 0; mask_ld = 0; ctr_clr = 0; mask_set = 0; inc = 0; rexmit = 0;
    rb_ctr = 0; rb_mask = 0;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    addr_in = v; ld = 1; tick();
  endtask

  task automatic do_mask(input logic [W-1:0] v);
    addr_in = v; mask_ld = 1; tick();
  endtask

  task automatic read_mask(output logic [W-1:0] v);
    lat_sel = 0; rb_mask = 1; tick(); v = rb_data;
  endtask

  task automatic t_reset();
    logic [W-1:0] m;
    do_mask(21'h0000FC);
    do_load(21'h0ABCDE);
    #1 hard_clr = 1; #1;
    chk("R1 async counter clear", addr_out, '0);
    chk("R1 mask_bad clear", {20'd0, mask_bad}, '0);
    chk("R1 dq_oe high", {20'd0, dq_oe}, 21'd1);
    chk("R1 rb_valid low", {20'd0, rb_valid}, '0);
    @(negedge clk); hard_clr = 0;
    @(posedge clk); #1;
    read_mask(m);
    chk("R1 mask all ones", m, ALL);
    rexmit = 1; tick();
    chk("R1 mirror zero", addr_out, '0);
  endtask

  task automatic t_load_inc();
    do_load(21'h012345);
    chk("R2 load counter", addr_out, 21'h012345);
    inc = 1; tick();
    chk("R4 step one", addr_out, 21'h012346);
    rexmit = 1; tick();
    chk("R6 retransmit mirror", addr_out, 21'h012345);
    rexmit = 1; tick();
    chk("R6 mirror unchanged", addr_out, 21'h012345);
  endtask

  task automatic t_mask_step();
    logic [W-1:0] m;
    do_mask(21'h003FFC);
    read_mask(m);
    chk("R3 mask readback", m, 21'h003FFC);
    do_load(21'h1F0005);
    inc = 1; tick();
    chk("R4 step four frozen bits", addr_out, 21'h1F0009);
    do_mask(21'h1FFFFE);
    do_load(21'h000005);
    inc = 1; tick();
    chk("R4 step two", addr_out, 21'h000007);
  endtask

  task automatic t_wrap();
    do_mask(21'h00000F);
    do_load(21'h0001A3);
    for (int i = 0; i < 12; i++) begin
      inc = 1; tick();
    end
    chk("R5 field full", addr_out, 21'h0001AF);
    inc = 1; tick();
    chk("R5 wrap reload", addr_out, 21'h0001A3);
    inc = 1; tick();
    chk("R5 after wrap", addr_out, 21'h0001A4);
  endtask

  task automatic t_clear();
    do_mask(21'h0000FC);
    do_load(21'h01234F);
    ctr_clr = 1; tick();
    chk("R7 counting bits cleared", addr_out, 21'h012303);
    inc = 1; tick();
    chk("R7 count after clear", addr_out, 21'h012307);
    rexmit = 1; tick();
    chk("R7 mirror cleared", addr_out, 21'h012303);
  endtask

  task automatic t_mask_set();
    logic [W-1:0] m;
    do_mask(21'h0000FC);
    do_load(21'h1ABCDF);
    mask_set = 1; tick();
    read_mask(m);
    chk("R8 mask set", m, ALL);
    ctr_clr = 1; tick();
    chk("R8 counter zero", addr_out, '0);
    rexmit = 1; tick();
    chk("R8 mirror zero", addr_out, '0);
  endtask

  task automatic t_legal();
    do_mask(21'h02FFFF); chk("R9 02FFFF bad", {20'd0, mask_bad}, 21'd1);
    do_mask(21'h1FFFFE); chk("R9 1FFFFE ok", {20'd0, mask_bad}, 21'd0);
    do_mask(21'h003FFA); chk("R9 003FFA bad", {20'd0, mask_bad}, 21'd1);
    do_mask(21'h07FFFF); chk("R9 07FFFF ok", {20'd0, mask_bad}, 21'd0);
    do_mask(21'h07FFE4); chk("R9 07FFE4 bad", {20'd0, mask_bad}, 21'd1);
    do_mask(21'h003FFC); chk("R9 003FFC ok", {20'd0, mask_bad}, 21'd0);
    do_mask(21'h000000); chk("R9 zero bad", {20'd0, mask_bad}, 21'd1);
    mask_set = 1; tick();
    chk("R9 cleared by mask set", {20'd0, mask_bad}, 21'd0);
  endtask

  task automatic t_readback();
    do_load(21'h000100);
    lat_sel = 0; rb_ctr = 1; inc = 1; tick();
    chk("R10 fast valid", {20'd0, rb_valid}, 21'd1);
    chk("R10 pre-increment value", rb_data, 21'h000100);
    chk("R11 oe low in readback", {20'd0, dq_oe}, 21'd0);
    chk("R4 counter moved", addr_out, 21'h000101);
    tick();
    chk("R11 oe back high", {20'd0, dq_oe}, 21'd1);
    lat_sel = 1; rb_ctr = 1; rb_mask = 1; inc = 1; tick();
    chk("R10 slow not yet", {20'd0, rb_valid}, 21'd0);
    tick();
    chk("R10 slow valid", {20'd0, rb_valid}, 21'd1);
    chk("R10 counter wins", rb_data, 21'h000101);
    chk("R11 oe low slow", {20'd0, dq_oe}, 21'd0);
    tick();
    chk("R10 single cycle", {20'd0, rb_valid}, 21'd0);
    lat_sel = 0;
  endtask

  task automatic t_priority();
    logic [W-1:0] m;
    do_load(21'h000055);
    addr_in = 21'h000077; ld = 1; inc = 1; tick();
    chk("R12 load over inc", addr_out, 21'h000077);
    inc = 1; tick();
    rexmit = 1; inc = 1; tick();
    chk("R12 rexmit over inc", addr_out, 21'h000077);
    addr_in = 21'h000099; ctr_clr = 1; ld = 1; tick();
    chk("R12 clear over load", addr_out, '0);
    addr_in = 21'h00000F; mask_set = 1; mask_ld = 1; tick();
    read_mask(m);
    chk("R12 mask set over mask load", m, ALL);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 hard_clr = 0;
    t_reset();
    t_load_inc();
    t_mask_step();
    t_wrap();
    t_clear();
    t_mask_set();
    t_legal();
    t_readback();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule